// File: doc/BRIEF.md
# Load/Store Address Generator

This unit works out the memory address for a 32-bit load or store. For instructions that modify their base register, it also produces the new base value. Each request supplies three things:

- a base value;
- the candidate offsets;
- a five-bit addressing control field.

The unit selects the offset, then adds it to the base or subtracts it. It then decides two things: whether the access uses the modified or the unmodified base, and whether the base register is written back. The register file, the barrel shifter and the memory sit outside the block. The shifted register operand arrives already shifted on `reg_off`.

There are two offset families:

- **Primary family** (word and byte accesses). The offset is a 12-bit immediate or the register operand.
- **Extended family** (halfword, signed and doubleword accesses). The offset is an 8-bit immediate built from two 4-bit halves, or the register operand.

A small attribute decoder reports the load/store direction and a size code for each request. All results are registered once and qualified by a valid strobe.

Top module: `ls_agu`

## Requirements
- R1: With `ctrl[4]`=1 (pre-index), `o_addr` equals base plus or minus the selected offset.
- R2: With `ctrl[4]`=0 (post-index), `o_addr` equals the unmodified base.
- R3: With `ctrl[4]`=0, `o_base_we` is 1 whatever the value of `ctrl[1]`, and `o_base_new` is base plus or minus the offset. So codes that differ only in `ctrl[1]` give identical results.
- R4: With `ctrl[4]`=1, `o_base_we` equals `ctrl[1]`, and `o_base_new` is base plus or minus the offset.
- R5: The up/down bit selects the direction: `ctrl[3]`=1 adds the offset and `ctrl[3]`=0 subtracts it. All arithmetic wraps modulo 2^32.
- R6: In the primary family (`family`=0), the offset is `imm12` zero-extended when `use_reg`=0, and `reg_off` when `use_reg`=1.
- R7: In the extended family (`family`=1), the offset is `{imm_hi,imm_lo}` zero-extended when `ctrl[2]`=1, and `reg_off` when `ctrl[2]`=0. In this family `use_reg` has no effect.
- R8: In the primary family, `o_load` equals `ctrl[0]`. `o_size` is 3'b000 (unsigned byte) when `ctrl[2]`=1 and 3'b010 (word) when `ctrl[2]`=0. Size code bit 2 means sign-extend, and bits 1:0 give log2 of the byte count.
- R9: In the extended family, `xkind` and `ctrl[0]` select the access as follows:

  | `xkind` | `ctrl[0]` | Access | `o_load` | `o_size` |
  |---|---|---|---|---|
  | 2'b01 or 2'b00 | any | unsigned halfword | `ctrl[0]` | 3'b001 |
  | 2'b10 | 1 | signed byte | 1 | 3'b100 |
  | 2'b10 | 0 | doubleword load | 1 | 3'b011 |
  | 2'b11 | 1 | signed halfword | 1 | 3'b101 |
  | 2'b11 | 0 | doubleword store | 0 | 3'b011 |

- R10: All outputs are registered with one cycle of latency. `o_valid` follows `req_valid`, and `o_base_we` is 0 in any cycle where `o_valid` is 0.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| family | input | 1 | 0 = word/byte family, 1 = halfword/signed/doubleword family |
| use_reg | input | 1 | Primary family: 1 selects the register offset, 0 the 12-bit immediate |
| xkind | input | 2 | Extended family access kind |
| ctrl | input | 5 | {pre, up, byte-or-imm, writeback, load} |
| base | input | 32 | Base register value |
| imm12 | input | 12 | Primary family immediate |
| imm_hi | input | 4 | Extended immediate, high half |
| imm_lo | input | 4 | Extended immediate, low half |
| reg_off | input | 32 | Register offset, already shifted |
| o_valid | output | 1 | Results valid |
| o_addr | output | 32 | Effective address |
| o_base_new | output | 32 | Updated base value |
| o_base_we | output | 1 | Base writeback enable |
| o_load | output | 1 | 1 = load, 0 = store |
| o_size | output | 3 | {sign-extend, log2 bytes} |

## Verification
The bench sweeps all 32 control codes in both families against its own model of the pre/post/writeback rules, and targets these faults:

- **Writeback gated by the W bit on post-index.** A design that does this would drop base updates for half of the post-indexed codes.
- **Swapped address choice.** A design that swaps the modified and unmodified base would hand the wrong address to memory on every post-indexed access.
- **Bad wraparound or direction.** Subtracting past zero and adding past 2^32 expose any carry or direction error, and a sign-extended immediate would also show there.
- **Doubleword encodings.** These catch a decoder that simply forwards `ctrl[0]` as the direction, which would turn a doubleword load into a store.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
   typedef struct packed {
      logic pre;   // 1: address uses modified base
      logic up;    // 1: add offset, 0: subtract
      logic bi;    // byte (primary) or immediate (extended)
      logic wb;    // writeback request for pre-index
      logic ld;    // 1: load
   } agu_ctrl_t;

   localparam logic [2:0] SZ_UBYTE = 3'b000;
   localparam logic [2:0] SZ_UHALF = 3'b001;
   localparam logic [2:0] SZ_WORD  = 3'b010;
   localparam logic [2:0] SZ_DWORD = 3'b011;
   localparam logic [2:0] SZ_SBYTE = 3'b100;
   localparam logic [2:0] SZ_SHALF = 3'b101;
endpackage

// File: rtl/ls_agu_offset.sv
module ls_agu_offset #(
   parameter int AW    = 32,
   parameter int IMM_W = 12,
   parameter int NIB_W = 4
) (
   input  logic             family,
   input  logic             use_reg,
   input  logic             bi,
   input  logic [IMM_W-1:0] imm12,
   input  logic [NIB_W-1:0] imm_hi,
   input  logic [NIB_W-1:0] imm_lo,
   input  logic [AW-1:0]    reg_off,
   output logic [AW-1:0]    offset
);
   localparam int PAD_P = AW - IMM_W;
   localparam int PAD_X = AW - 2*NIB_W;

   logic [AW-1:0] prim_imm;
   logic [AW-1:0] ext_imm;

   assign prim_imm = {{PAD_P{1'b0}}, imm12};
   assign ext_imm  = {{PAD_X{1'b0}}, imm_hi, imm_lo};

   always_comb begin
      if (family) offset = bi ? ext_imm : reg_off;
      else        offset = use_reg ? reg_off : prim_imm;
   end
endmodule

// File: rtl/ls_agu_addsub.sv
module ls_agu_addsub #(
   parameter int AW      = 32,
   parameter bit NEG_ADD = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] offset,
   input  logic          up,
   output logic [AW-1:0] sum
);
   generate
      if (NEG_ADD) begin : g_negadd
         logic [AW-1:0] operand;
         assign operand = up ? offset : (~offset + {{(AW-1){1'b0}}, 1'b1});
         assign sum     = base + operand;
      end else begin : g_mux
         logic [AW-1:0] s_add;
         logic [AW-1:0] s_sub;
         assign s_add = base + offset;
         assign s_sub = base - offset;
         assign sum   = up ? s_add : s_sub;
      end
   endgenerate
endmodule

// File: rtl/ls_agu_attr.sv
module ls_agu_attr
   import ls_agu_pkg::*;
(
   input  logic       family,
   input  logic [1:0] xkind,
   input  logic       bi,
   input  logic       ld,
   output logic       load,
   output logic [2:0] size
);
   always_comb begin
      load = ld;
      size = SZ_WORD;
      if (!family) begin
         size = bi ? SZ_UBYTE : SZ_WORD;
      end else begin
         case (xkind)
            2'b10: begin
               load = 1'b1;
               size = ld ? SZ_SBYTE : SZ_DWORD;
            end
            2'b11: begin
               load = ld;
               size = ld ? SZ_SHALF : SZ_DWORD;
            end
            default: begin
               load = ld;
               size = SZ_UHALF;
            end
         endcase
      end
   end
endmodule

// File: rtl/ls_agu.sv
module ls_agu
   import ls_agu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int IMM_W   = 12,
   parameter int NIB_W   = 4,
   parameter bit NEG_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             family,
   input  logic             use_reg,
   input  logic [1:0]       xkind,
   input  logic [4:0]       ctrl,
   input  logic [AW-1:0]    base,
   input  logic [IMM_W-1:0] imm12,
   input  logic [NIB_W-1:0] imm_hi,
   input  logic [NIB_W-1:0] imm_lo,
   input  logic [AW-1:0]    reg_off,
   output logic             o_valid,
   output logic [AW-1:0]    o_addr,
   output logic [AW-1:0]    o_base_new,
   output logic             o_base_we,
   output logic             o_load,
   output logic [2:0]       o_size
);
   generate
      if (IMM_W >= AW) begin : g_bad_imm
         $error("ls_agu: IMM_W must be narrower than AW");
      end
      if (2*NIB_W >= AW) begin : g_bad_nib
         $error("ls_agu: 2*NIB_W must be narrower than AW");
      end
   endgenerate

   agu_ctrl_t     cf;
   logic [AW-1:0] offset;
   logic [AW-1:0] sum;
   logic          load_d;
   logic [2:0]    size_d;
   logic [AW-1:0] addr_d;
   logic          we_d;

   assign cf = agu_ctrl_t'(ctrl);

   ls_agu_offset #(.AW(AW), .IMM_W(IMM_W), .NIB_W(NIB_W)) u_offset (
      .family (family),
      .use_reg(use_reg),
      .bi     (cf.bi),
      .imm12  (imm12),
      .imm_hi (imm_hi),
      .imm_lo (imm_lo),
      .reg_off(reg_off),
      .offset (offset)
   );

   ls_agu_addsub #(.AW(AW), .NEG_ADD(NEG_ADD)) u_addsub (
      .base  (base),
      .offset(offset),
      .up    (cf.up),
      .sum   (sum)
   );

   ls_agu_attr u_attr (
      .family(family),
      .xkind (xkind),
      .bi    (cf.bi),
      .ld    (cf.ld),
      .load  (load_d),
      .size  (size_d)
   );

   // pre-index uses the modified base; post-index always writes back
   assign addr_d = cf.pre ? sum : base;
   assign we_d   = cf.pre ? cf.wb : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid    <= 1'b0;
         o_addr     <= '0;
         o_base_new <= '0;
         o_base_we  <= 1'b0;
         o_load     <= 1'b0;
         o_size     <= '0;
      end else begin
         o_valid    <= req_valid;
         o_addr     <= addr_d;
         o_base_new <= sum;
         o_base_we  <= req_valid & we_d;
         o_load     <= load_d;
         o_size     <= size_d;
      end
   end
endmodule

// File: rtl/ls_agu_chk.sv
module ls_agu_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          family,
   input logic [4:0]    ctrl,
   input logic [AW-1:0] base,
   input logic          o_valid,
   input logic [AW-1:0] o_addr,
   input logic [AW-1:0] o_base_new,
   input logic          o_base_we,
   input logic          o_load
);
   p_pre_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $past(ctrl[4])) |-> (o_addr == o_base_new));

   p_post_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !$past(ctrl[4])) |-> (o_addr == $past(base)));

   p_post_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !$past(ctrl[4])) |-> o_base_we);

   p_pre_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $past(ctrl[4])) |-> (o_base_we == $past(ctrl[1])));

   p_prim_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !$past(family)) |-> (o_load == $past(ctrl[0])));

   p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> $past(req_valid));

   p_idle_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !o_valid |-> !o_base_we);
endmodule

bind ls_agu ls_agu_chk #(.AW(AW)) u_ls_agu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .family    (family),
   .ctrl      (ctrl),
   .base      (base),
   .o_valid   (o_valid),
   .o_addr    (o_addr),
   .o_base_new(o_base_new),
   .o_base_we (o_base_we),
   .o_load    (o_load)
);

// File: tb/test_ls_agu.sv
`timescale 1ns/1ps
module test_ls_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        family = 1'b0;
   logic        use_reg = 1'b0;
   logic [1:0]  xkind = 2'b01;
   logic [4:0]  ctrl = '0;
   logic [31:0] base = '0;
   logic [11:0] imm12 = '0;
   logic [3:0]  imm_hi = '0;
   logic [3:0]  imm_lo = '0;
   logic [31:0] reg_off = '0;
   logic        o_valid;
   logic [31:0] o_addr;
   logic [31:0] o_base_new;
   logic        o_base_we;
   logic        o_load;
   logic [2:0]  o_size;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ls_agu i_ls_agu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .family(family),
      .use_reg(use_reg), .xkind(xkind), .ctrl(ctrl), .base(base),
      .imm12(imm12), .imm_hi(imm_hi), .imm_lo(imm_lo), .reg_off(reg_off),
      .o_valid(o_valid), .o_addr(o_addr), .o_base_new(o_base_new),
      .o_base_we(o_base_we), .o_load(o_load), .o_size(o_size)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one request, check the registered results one cycle later
   task automatic apply_and_check(input logic fam, input logic ur, input logic [1:0] xk,
                                  input logic [4:0] c, input logic [31:0] b);
      logic [31:0] off, s, e_addr;
      logic        e_we, e_ld;
      logic [2:0]  e_sz;
      @(negedge clk);
      req_valid = 1'b1; family = fam; use_reg = ur; xkind = xk; ctrl = c; base = b;
      if (fam) off = c[2] ? {24'h0, imm_hi, imm_lo} : reg_off;
      else     off = ur ? reg_off : {20'h0, imm12};
      s      = c[3] ? b + off : b - off;
      e_addr = c[4] ? s : b;
      e_we   = c[4] ? c[1] : 1'b1;
      e_ld   = c[0];
      if (!fam) e_sz = c[2] ? 3'b000 : 3'b010;
      else if (xk == 2'b10) begin e_ld = 1'b1; e_sz = c[0] ? 3'b100 : 3'b011; end
      else if (xk == 2'b11) e_sz = c[0] ? 3'b101 : 3'b011;
      else e_sz = 3'b001;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 valid", {31'h0, o_valid}, 32'h1);
      if (c[4]) begin
         chk("R1 pre addr", o_addr, e_addr);
         chk("R4 pre we", {31'h0, o_base_we}, {31'h0, e_we});
         chk("R4 pre new base", o_base_new, s);
      end else begin
         chk("R2 post addr", o_addr, e_addr);
         chk("R3 post we", {31'h0, o_base_we}, {31'h0, e_we});
         chk("R3 post new base", o_base_new, s);
      end
      if (fam) begin
         chk("R9 load", {31'h0, o_load}, {31'h0, e_ld});
         chk("R9 size", {29'h0, o_size}, {29'h0, e_sz});
      end else begin
         chk("R8 load", {31'h0, o_load}, {31'h0, e_ld});
         chk("R8 size", {29'h0, o_size}, {29'h0, e_sz});
      end
   endtask

   task automatic t_reset;
      chk("R11 valid", {31'h0, o_valid}, 32'h0);
      chk("R11 addr", o_addr, 32'h0);
      chk("R11 base_new", o_base_new, 32'h0);
      chk("R11 we", {31'h0, o_base_we}, 32'h0);
      chk("R11 size", {29'h0, o_size}, 32'h0);
   endtask

   task automatic t_sweep_primary;   // R6 immediate and register offsets
      imm12 = 12'h0FF; reg_off = 32'h0000_0340;
      for (int c = 0; c < 32; c++) apply_and_check(1'b0, 1'b0, 2'b01, c[4:0], 32'h0000_1000);
      for (int c = 0; c < 32; c++) apply_and_check(1'b0, 1'b1, 2'b01, c[4:0], 32'h0000_1000);
   endtask

   task automatic t_sweep_extended;  // R7 split immediate, R9 kinds
      imm_hi = 4'hA; imm_lo = 4'h5; reg_off = 32'h0000_0123;
      for (int k = 0; k < 4; k++)
         for (int c = 0; c < 32; c++) apply_and_check(1'b1, k[0], k[1:0], c[4:0], 32'h0008_0000);
   endtask

   task automatic t_r3_pairs;        // post-index codes differing only in W match
      logic [31:0] a0, n0;
      logic        w0;
      imm12 = 12'h010;
      apply_and_check(1'b0, 1'b0, 2'b01, 5'h00, 32'h0000_2000);
      a0 = o_addr; n0 = o_base_new; w0 = o_base_we;
      apply_and_check(1'b0, 1'b0, 2'b01, 5'h02, 32'h0000_2000);
      chk("R3 pair addr", o_addr, a0);
      chk("R3 pair new base", o_base_new, n0);
      chk("R3 pair we", {31'h0, o_base_we}, {31'h0, w0});
   endtask

   task automatic t_wrap;            // R5 modulo 2^32
      imm12 = 12'h010;
      apply_and_check(1'b0, 1'b0, 2'b01, 5'b10001, 32'h0000_0004);
      chk("R5 wrap down", o_addr, 32'hFFFF_FFF4);
      imm12 = 12'h020;
      apply_and_check(1'b0, 1'b0, 2'b01, 5'b11001, 32'hFFFF_FFF0);
      chk("R5 wrap up", o_addr, 32'h0000_0010);
      imm12 = 12'hFFF;
      apply_and_check(1'b0, 1'b0, 2'b01, 5'b11001, 32'h0000_0001);
      chk("R6 zero extend", o_addr, 32'h0000_1000);
   endtask

   task automatic t_idle;            // R10 no writeback without a request
      @(negedge clk);
      req_valid = 1'b0; ctrl = 5'b10010; family = 1'b0;
      @(negedge clk);
      chk("R10 idle valid", {31'h0, o_valid}, 32'h0);
      chk("R10 idle we", {31'h0, o_base_we}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_sweep_primary();
      t_sweep_extended();
      t_r3_pairs();
      t_wrap();
      t_idle();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule